// File: doc/BRIEF.md
# Programmable Pseudo-Random Bit Sequence Checker with Error-Rate Counters

This block tests a received serial bit stream against a pseudo-random sequence defined by a run-time tap mask. A mode input steers it through four phases. Idle clears everything. Seed fills a local history register from the received bits. Run predicts each next bit from that history and counts compared bits and mismatches. Hold freezes both counters so software can read them.

Bits arrive one per transfer from one of three sources, chosen by a select input. Each source has a valid/ready pair. The checker never applies back-pressure: the selected source sees ready high whenever reset is released. Unselected sources see ready low and their transfers are not consumed. Counters are 64 bits wide. They saturate rather than wrap, and each is read out as an upper and a lower 32-bit half.

Top module: `prbs_ber_checker`

## Requirements
- R1: While `rst_n` is low, all four counter halves read 0 and every source ready is low.
- R2: In mode 1 (seed), each accepted bit is shifted into the history as its newest entry, and neither counter changes.
- R3: In mode 0 (idle), both counters and the history are cleared on the next clock.
- R4: In mode 2 (run), each accepted bit adds one to the total count. It adds one to the error count when it differs from the predicted bit. The predicted bit, not the received one, then enters the history.
- R5: In mode 3 (hold), the counters and the history keep their values, and accepted bits have no effect on any output.
- R6: Both counters stop at their all-ones value instead of wrapping.
- R7: `*_hi` carries counter bits [63:32] and `*_lo` carries bits [31:0].
- R8: Source select 0 picks the ADC path, 1 the equalizer path and 3 the self-test path. Code 2 picks nothing. Only the selected source sees ready high, and valid on any other source is ignored.
- R9: The predicted bit is the XOR of the history bits whose positions are set in `tap_mask`, where bit i holds the bit received i+1 transfers earlier. Mask 0x100002 gives the 21-stage sequence x[n] = x[n-2] ^ x[n-21].
- R10: The selected source's ready is high in every cycle with `rst_n` high, whatever the mode, so no back-pressure is ever applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 idle, 1 seed, 2 run, 3 hold |
| src_sel | input | 2 | 0 ADC, 1 equalizer, 2 none, 3 self-test |
| tap_mask | input | 32 | Polynomial tap mask over the history |
| adc_valid | input | 1 | ADC source bit valid |
| adc_bit | input | 1 | ADC source data bit |
| adc_ready | output | 1 | ADC source ready |
| eq_valid | input | 1 | Equalizer source bit valid |
| eq_bit | input | 1 | Equalizer source data bit |
| eq_ready | output | 1 | Equalizer source ready |
| bist_valid | input | 1 | Self-test source bit valid |
| bist_bit | input | 1 | Self-test source data bit |
| bist_ready | output | 1 | Self-test source ready |
| err_hi | output | 32 | Error count, upper half |
| err_lo | output | 32 | Error count, lower half |
| tot_hi | output | 32 | Total count, upper half |
| tot_lo | output | 32 | Total count, lower half |

## Verification
Saturation is the hardest state to reach: at the default 64-bit width the counters cannot fill within any run. A second instance with 8-bit counters therefore receives the same stimulus, and a long run drives its total past 255 while injected errors add to its error count. A second hard case is proving that a frozen or unselected transfer has no effect. The bench keeps valid high on every unselected source with inverted data, and keeps sending corrupted bits during hold, so any leak would show up in the per-clock comparison. The tap mask is also changed between runs, to cover a short polynomial as well as the 21-stage one.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_SEED = 2'd1,
    MODE_RUN  = 2'd2,
    MODE_HOLD = 2'd3
  } chk_mode_e;

  typedef enum logic [1:0] {
    SRC_ADC  = 2'd0,
    SRC_EQ   = 2'd1,
    SRC_NONE = 2'd2,
    SRC_BIST = 2'd3
  } src_sel_e;

  localparam int NUM_SRC_CODES = 4;
endpackage

// File: rtl/prbs_src_mux.sv
module prbs_src_mux
  import prbs_chk_pkg::*;
(
  input  logic                     rst_n,
  input  logic [1:0]               sel,
  input  logic [NUM_SRC_CODES-1:0] vld,
  input  logic [NUM_SRC_CODES-1:0] dat,
  output logic [NUM_SRC_CODES-1:0] rdy,
  output logic                     take,
  output logic                     rx_bit
);
  for (genvar k = 0; k < NUM_SRC_CODES; k++) begin : g_rdy
    if (k == int'(SRC_NONE)) begin : g_none
      assign rdy[k] = 1'b0;
    end else begin : g_src
      assign rdy[k] = rst_n && (sel == k[1:0]);
    end
  end

  assign take   = |(rdy & vld);
  assign rx_bit = dat[sel];

  // R8: at most one source is offered ready
  always_comb begin
    a_r8_one_ready: assert ($onehot0(rdy));
  end
endmodule

// File: rtl/prbs_hist_lfsr.sv
module prbs_hist_lfsr #(
  parameter int HIST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic              shift_in,
  input  logic [HIST_W-1:0] mask,
  output logic              pred
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) hist_q <= '0;
    else if (shift)      hist_q <= {hist_q[HIST_W-2:0], shift_in};
  end

  assign pred = ^(hist_q & mask);

  a_r2_newest_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clear) |=> hist_q[0] == $past(shift_in));
  a_r5_hist_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clear) |=> $stable(hist_q));
endmodule

// File: rtl/prbs_sat_ctr.sv
module prbs_sat_ctr #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)            cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clear) |=> cnt == CNT_MAX);
endmodule

// File: rtl/prbs_ber_checker.sv
module prbs_ber_checker
  import prbs_chk_pkg::*;
#(
  parameter int HIST_W = 32,
  parameter int CNT_W  = 64,
  localparam int HALF  = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [1:0]        src_sel,
  input  logic [HIST_W-1:0] tap_mask,
  input  logic              adc_valid,
  input  logic              adc_bit,
  output logic              adc_ready,
  input  logic              eq_valid,
  input  logic              eq_bit,
  output logic              eq_ready,
  input  logic              bist_valid,
  input  logic              bist_bit,
  output logic              bist_ready,
  output logic [HALF-1:0]   err_hi,
  output logic [HALF-1:0]   err_lo,
  output logic [HALF-1:0]   tot_hi,
  output logic [HALF-1:0]   tot_lo
);
  chk_mode_e               mode_e;
  logic [NUM_SRC_CODES-1:0] vld_v, dat_v, rdy_v;
  logic                    take, rx_bit, pred;
  logic                    clr, hist_shift, hist_in, cnt_en, err_en;
  logic [CNT_W-1:0]        err_cnt, tot_cnt;

  assign mode_e = chk_mode_e'(mode);
  assign vld_v  = {bist_valid, 1'b0, eq_valid, adc_valid};
  assign dat_v  = {bist_bit,   1'b0, eq_bit,   adc_bit};

  prbs_src_mux u_mux (
    .rst_n (rst_n), .sel (src_sel), .vld (vld_v), .dat (dat_v),
    .rdy (rdy_v), .take (take), .rx_bit (rx_bit)
  );

  assign adc_ready  = rdy_v[SRC_ADC];
  assign eq_ready   = rdy_v[SRC_EQ];
  assign bist_ready = rdy_v[SRC_BIST];

  assign clr        = (mode_e == MODE_IDLE);
  assign hist_shift = take && (mode_e == MODE_SEED || mode_e == MODE_RUN);
  assign hist_in    = (mode_e == MODE_SEED) ? rx_bit : pred;
  assign cnt_en     = take && (mode_e == MODE_RUN);
  assign err_en     = cnt_en && (rx_bit != pred);

  prbs_hist_lfsr #(.HIST_W(HIST_W)) u_hist (
    .clk (clk), .rst_n (rst_n), .clear (clr), .shift (hist_shift),
    .shift_in (hist_in), .mask (tap_mask), .pred (pred)
  );

  prbs_sat_ctr #(.CW(CNT_W)) u_err (
    .clk (clk), .rst_n (rst_n), .clear (clr), .inc (err_en), .cnt (err_cnt)
  );
  prbs_sat_ctr #(.CW(CNT_W)) u_tot (
    .clk (clk), .rst_n (rst_n), .clear (clr), .inc (cnt_en), .cnt (tot_cnt)
  );

  assign err_hi = err_cnt[CNT_W-1:HALF];
  assign err_lo = err_cnt[HALF-1:0];
  assign tot_hi = tot_cnt[CNT_W-1:HALF];
  assign tot_lo = tot_cnt[HALF-1:0];

  a_r3_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_IDLE) |=> (err_cnt == '0 && tot_cnt == '0));
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_HOLD) |=> ($stable(err_cnt) && $stable(tot_cnt)));
  a_r2_seed_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_SEED) |=> ($stable(err_cnt) && $stable(tot_cnt)));
  a_r4_err_le_tot: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= tot_cnt);
  a_r10_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != SRC_NONE) |-> $countones(rdy_v) == 1);
endmodule

// File: tb/sim_prbs_ber_checker.sv
module sim_prbs_ber_checker;
  localparam time CLK_PERIOD = 10ns;
  localparam longint unsigned SMALL_MAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0, src_sel = 2'd1;
  logic [31:0] tap_mask = 32'h0010_0002;
  logic adc_valid = 0, adc_bit = 0, eq_valid = 0, eq_bit = 0, bist_valid = 0, bist_bit = 0;
  logic adc_ready, eq_ready, bist_ready, a1, e1, b1;
  logic [31:0] err_hi, err_lo, tot_hi, tot_lo;
  logic [3:0] s_err_hi, s_err_lo, s_tot_hi, s_tot_lo;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  longint unsigned m_tot = 0, m_err = 0;
  bit hist[$];
  bit gen[$];
  logic [31:0] gmask;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_ber_checker u0 (
    .clk, .rst_n, .mode, .src_sel, .tap_mask,
    .adc_valid, .adc_bit, .adc_ready, .eq_valid, .eq_bit, .eq_ready,
    .bist_valid, .bist_bit, .bist_ready,
    .err_hi, .err_lo, .tot_hi, .tot_lo
  );

  prbs_ber_checker #(.CNT_W(8)) u1 (
    .clk, .rst_n, .mode, .src_sel, .tap_mask,
    .adc_valid, .adc_bit, .adc_ready(a1), .eq_valid, .eq_bit, .eq_ready(e1),
    .bist_valid, .bist_bit, .bist_ready(b1),
    .err_hi(s_err_hi), .err_lo(s_err_lo), .tot_hi(s_tot_hi), .tot_lo(s_tot_lo)
  );

  task automatic hist_clear();
    hist.delete();
    for (int i = 0; i < 32; i++) hist.push_back(1'b0);
  endtask

  function automatic bit model_pred();
    bit x = 0;
    for (int i = 0; i < 32; i++) if (tap_mask[i]) x ^= hist[i];
    return x;
  endfunction

  task automatic gen_reset(input logic [31:0] m);
    gmask = m;
    gen.delete();
    for (int i = 0; i < 32; i++) gen.push_back(1'b1);
  endtask

  function automatic bit gen_next();
    bit x = 0;
    for (int i = 0; i < 32; i++) if (gmask[i]) x ^= gen[i];
    gen.push_front(x);
    void'(gen.pop_back());
    return x;
  endfunction

  task automatic check(input bit ok, input string what, input longint unsigned act,
                       input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit tk, rx, p;
    tk = (src_sel == 2'd0 && adc_valid) || (src_sel == 2'd1 && eq_valid) ||
         (src_sel == 2'd3 && bist_valid);
    rx = (src_sel == 2'd0) ? adc_bit : (src_sel == 2'd1) ? eq_bit : bist_bit;
    if (!rst_n || mode == 2'd0) begin
      m_tot = 0; m_err = 0; hist_clear();
    end else if (tk && mode == 2'd1) begin
      hist.push_front(rx); void'(hist.pop_back());
    end else if (tk && mode == 2'd2) begin
      p = model_pred();
      m_tot++;
      if (rx != p) m_err++;
      hist.push_front(p); void'(hist.pop_back());
    end
  endtask

  task automatic compare();
    longint unsigned se, st;
    logic [2:0] er;
    se = (m_err > SMALL_MAX) ? SMALL_MAX : m_err;
    st = (m_tot > SMALL_MAX) ? SMALL_MAX : m_tot;
    check({err_hi, err_lo} == m_err, "err count", {err_hi, err_lo}, m_err);
    check({tot_hi, tot_lo} == m_tot, "total count", {tot_hi, tot_lo}, m_tot);
    check({s_err_hi, s_err_lo} == se, "R6 small err", {s_err_hi, s_err_lo}, se);
    check({s_tot_hi, s_tot_lo} == st, "R6 small total", {s_tot_hi, s_tot_lo}, st);
    er = {rst_n && src_sel == 2'd3, rst_n && src_sel == 2'd1, rst_n && src_sel == 2'd0};
    check({bist_ready, eq_ready, adc_ready} == er, "R8 R10 ready",
          {bist_ready, eq_ready, adc_ready}, er);
  endtask

  // inputs were set right after a falling edge; model follows the rising edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    compare();
    @(negedge clk);
  endtask

  // drive one bit on the selected source, inverted noise on the others
  task automatic send(input bit b, input bit v);
    adc_valid = 1; eq_valid = 1; bist_valid = 1;
    adc_bit = ~b; eq_bit = ~b; bist_bit = ~b;
    case (src_sel)
      2'd0: begin adc_bit = b; adc_valid = v; end
      2'd1: begin eq_bit = b; eq_valid = v; end
      2'd3: begin bist_bit = b; bist_valid = v; end
      default: ;
    endcase
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    hist_clear();
    gen_reset(32'h0010_0002);
    @(negedge clk);
    tag = "R1";
    repeat (3) send(1'b1, 1'b1);
    rst_n = 1;
    mode = 2'd0; cyc();

    // R2 R8: seed from equalizer path with noise on the others
    tag = "R2"; mode = 2'd1; src_sel = 2'd1;
    for (int i = 0; i < 40; i++) send(gen_next(), 1'b1);

    // R4 R9 R7: clean run with valid gaps, totals pass the 8-bit limit (R6)
    tag = "R4"; mode = 2'd2;
    for (int i = 0; i < 300; i++) begin
      if (i % 7 == 3) send(1'b0, 1'b0);
      send(gen_next(), 1'b1);
    end
    // R4 R6: injected errors
    tag = "R6";
    for (int i = 0; i < 280; i++) send(gen_next() ^ (i % 2 == 0), 1'b1);
    tag = "R9";
    for (int i = 0; i < 30; i++) send(gen_next(), 1'b1);

    // R5: hold with corrupted bits still arriving
    tag = "R5"; mode = 2'd3;
    for (int i = 0; i < 20; i++) send(~gen_next(), 1'b1);
    tag = "R7"; check(tot_lo == m_tot[31:0] && tot_hi == 0, "R7 halves", tot_lo, m_tot);

    // R3: idle clears
    tag = "R3"; mode = 2'd0; send(1'b0, 1'b1);
    check(m_tot == 0, "R3 model cleared", m_tot, 0);

    // R8: self-test source, then select code 2 consumes nothing
    tag = "R8"; src_sel = 2'd3; mode = 2'd1; gen_reset(32'h0010_0002);
    for (int i = 0; i < 32; i++) send(gen_next(), 1'b1);
    mode = 2'd2; src_sel = 2'd2;
    for (int i = 0; i < 10; i++) send(1'b1, 1'b1);
    src_sel = 2'd3;
    for (int i = 0; i < 20; i++) send(gen_next(), 1'b1);

    // R9: runtime mask change to a 7-stage polynomial on the ADC path
    tag = "R9"; mode = 2'd0; tap_mask = 32'h0000_0060; src_sel = 2'd0; send(1'b0, 1'b0);
    gen_reset(32'h0000_0060); mode = 2'd1;
    for (int i = 0; i < 10; i++) send(gen_next(), 1'b1);
    mode = 2'd2;
    for (int i = 0; i < 60; i++) send(gen_next() ^ (i == 25), 1'b1);
    check(m_err == 1, "R9 single error", m_err, 1);

    // R10: ready stays up across modes
    tag = "R10"; mode = 2'd3; send(1'b0, 1'b1);
    mode = 2'd1; send(1'b0, 1'b0);

    // R1: reset again mid-stream
    tag = "R1"; rst_n = 0; send(1'b1, 1'b1); send(1'b1, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule